// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a stereo serial audio stream into parallel samples. The stream has three wires: a bit clock, a word clock and serial data. All three are brought into a faster system clock domain through synchronizer flops, and the edges of the bit clock are found there. Only those edges move the receive logic forward, so the bit clock may stop between bursts. The receiver outputs a left/right pair of 18-bit two's-complement samples together with a one-cycle valid strobe.

A 2-bit format input picks one of four framings. Right-justified, I2S and left-justified use the word-clock level to name the channel. The DSP-style format marks the start of each word with a short high pulse on the word clock. A separate input picks 16-bit or 18-bit words. A 16-bit word is placed in the top of the 18-bit output, with two zero bits below it. In right-justified mode the receiver keeps a rolling history of the most recent bits and takes a word from it at each word-clock change. Because of this it accepts both 64-clock frames and 32-clock packed frames.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is held, and after it is released before any word completes, `left_o`, `right_o` and `valid_o` are all zero.
- R2: With `fmt_i` = 2'b10 (left-justified), data is sampled on rising bit-clock edges. The MSB is the first bit sampled after a word-clock change, and a high word clock marks the left word.
- R3: With `fmt_i` = 2'b01 (I2S), data is sampled on rising bit-clock edges. The MSB is the second bit sampled after a word-clock change, and a low word clock marks the left word.
- R4: With `fmt_i` = 2'b00 (right-justified), the word is the last N bits sampled on rising edges before a word-clock change. A high word clock marks the left word. This holds for 64-clock frames and for 32-clock packed frames with 16-bit words.
- R5: With `fmt_i` = 2'b11 (DSP style), data is sampled on falling bit-clock edges. The MSB is the first bit sampled low after the word clock was sampled high. The first pulse after reset carries the left word, and the channels alternate after that.
- R6: Words arrive MSB first. With `wide_i` = 1, the 18 received bits fill the output. With `wide_i` = 0, the 16 received bits fill bits 17:2 and bits 1:0 are zero.
- R7: `valid_o` pulses high for exactly one cycle when a right word completes, and never when only a left word completes. `left_o` and `right_o` change only in a cycle where `valid_o` is high.
- R8: Only bit-clock edges advance reception. A stopped bit clock of any length between bits does not change the received words, and every `valid_o` pulse follows a detected bit-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock, may be gated |
| wclk_i | input | 1 | Word clock / frame pulse |
| sdata_i | input | 1 | Serial audio data |
| fmt_i | input | 2 | Framing format: 00 right-justified, 01 I2S, 10 left-justified, 11 DSP style |
| wide_i | input | 1 | Word length: 1 = 18 bits, 0 = 16 bits |
| left_o | output | 18 | Left sample, two's complement |
| right_o | output | 18 | Right sample, two's complement |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |

## Verification
The assertions check several properties on every cycle. The strobe lasts one cycle, and the outputs hold unless it is high. The low two bits are zero for 16-bit words. The sampling edge matches the format: a rising edge everywhere except DSP style, which uses a falling edge. Every strobe follows a bit-clock edge by the fixed pipeline depth. Only the bench's framed scenarios can show that the bit positions are correct: where the MSB sits in each format, which channel each word-clock level or pulse selects, that packed frames and bursty clocks are accepted, and that no strobe appears after a left word alone.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_I2S = 2'b01,
    FMT_LJ  = 2'b10,
    FMT_DSP = 2'b11
  } sar_fmt_e;
endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic wclk_i,
  input  logic sdata_i,
  output logic bclk_lvl,
  output logic wclk_lvl,
  output logic sdata_lvl,
  output logic bclk_rise,
  output logic bclk_fall
);
  // bundle order: {bit clock, word clock, data}; all three see equal delay
  logic [2:0] stg [STAGES+1];
  logic       bclk_last;

  assign stg[0] = {bclk_i, wclk_i, sdata_i};

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i+1] <= 3'b000;
      else        stg[i+1] <= stg[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_last <= 1'b0;
    else        bclk_last <= stg[STAGES][2];
  end

  assign bclk_lvl  = stg[STAGES][2];
  assign wclk_lvl  = stg[STAGES][1];
  assign sdata_lvl = stg[STAGES][0];
  assign bclk_rise = bclk_lvl & ~bclk_last;
  assign bclk_fall = ~bclk_lvl & bclk_last;
endmodule

// File: rtl/sar_framer.sv
module sar_framer
  import sar_pkg::*;
#(
  parameter int W  = 18,
  parameter int NW = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt_i,
  input  logic         lr_i,
  input  logic         d_i,
  input  sar_fmt_e     fmt_i,
  input  logic         wide_i,
  output logic         done_vld_o,
  output logic         done_right_o,
  output logic [W-1:0] done_word_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LEN_W = CW'(W);
  localparam logic [CW-1:0] LEN_N = CW'(NW);

  logic          lr_prev, lr_prev_n;
  logic [W-1:0]  sh, sh_n, sh_shift;
  logic          act, act_n;
  logic [CW-1:0] cnt, cnt_n, cnt_inc, len;
  logic          rgt, rgt_n;
  logic          flip, flip_n;
  logic          dv_n, dr_n;
  logic [W-1:0]  dw_n;
  logic          start, start_right;

  function automatic logic [W-1:0] fit(input logic [W-1:0] v, input logic wide);
    return wide ? v : {v[NW-1:0], {(W-NW){1'b0}}};
  endfunction

  assign sh_shift = {sh[W-2:0], d_i};
  assign cnt_inc  = cnt + 1'b1;
  assign len      = wide_i ? LEN_W : LEN_N;

  always_comb begin
    if (fmt_i == FMT_DSP) start = lr_prev & ~lr_i;
    else                  start = lr_prev ^ lr_i;
    unique case (fmt_i)
      FMT_I2S: start_right = lr_i;
      FMT_DSP: start_right = flip;
      default: start_right = ~lr_i;
    endcase
  end

  always_comb begin
    lr_prev_n = lr_prev;
    sh_n      = sh;
    act_n     = act;
    cnt_n     = cnt;
    rgt_n     = rgt;
    flip_n    = flip;
    dv_n      = 1'b0;
    dr_n      = done_right_o;
    dw_n      = done_word_o;
    if (evt_i) begin
      lr_prev_n = lr_i;
      sh_n      = sh_shift;
      if (fmt_i == FMT_RJ) begin
        if (start) begin
          dv_n = 1'b1;
          dr_n = ~lr_prev;
          dw_n = fit(sh, wide_i);
        end
      end else if (start) begin
        act_n = 1'b1;
        rgt_n = start_right;
        cnt_n = (fmt_i == FMT_I2S) ? '0 : CW'(1);
        if (fmt_i == FMT_DSP) flip_n = ~flip;
      end else if (act) begin
        cnt_n = cnt_inc;
        if (cnt_inc == len) begin
          act_n = 1'b0;
          dv_n  = 1'b1;
          dr_n  = rgt;
          dw_n  = fit(sh_shift, wide_i);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_prev      <= 1'b0;
      sh           <= '0;
      act          <= 1'b0;
      cnt          <= '0;
      rgt          <= 1'b0;
      flip         <= 1'b0;
      done_vld_o   <= 1'b0;
      done_right_o <= 1'b0;
      done_word_o  <= '0;
    end else begin
      lr_prev      <= lr_prev_n;
      sh           <= sh_n;
      act          <= act_n;
      cnt          <= cnt_n;
      rgt          <= rgt_n;
      flip         <= flip_n;
      done_vld_o   <= dv_n;
      done_right_o <= dr_n;
      done_word_o  <= dw_n;
    end
  end
endmodule

// File: rtl/sar_pair_out.sv
module sar_pair_out #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         done_vld_i,
  input  logic         done_right_i,
  input  logic [W-1:0] done_word_i,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         valid_o
);
  logic [W-1:0] pend_l, pend_l_n, left_n, right_n;
  logic         valid_n;
  logic         take_left, take_pair;

  assign take_left = done_vld_i & ~done_right_i;
  assign take_pair = done_vld_i &  done_right_i;

  always_comb begin
    pend_l_n = take_left ? done_word_i : pend_l;
    left_n   = take_pair ? pend_l      : left_o;
    right_n  = take_pair ? done_word_i : right_o;
    valid_n  = take_pair;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_l  <= '0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      pend_l  <= pend_l_n;
      left_o  <= left_n;
      right_o <= right_n;
      valid_o <= valid_n;
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sar_pkg::*;
#(
  parameter int WORD_W      = 18,
  parameter int NARROW_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              wclk_i,
  input  logic              sdata_i,
  input  logic [1:0]        fmt_i,
  input  logic              wide_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  sar_fmt_e          fmt;
  logic              bclk_lvl, wclk_lvl, sdata_lvl, bclk_rise, bclk_fall;
  logic              bit_evt;
  logic              done_vld, done_right;
  logic [WORD_W-1:0] done_word;

  assign fmt     = sar_fmt_e'(fmt_i);
  assign bit_evt = (fmt == FMT_DSP) ? bclk_fall : bclk_rise;

  sar_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_i    (bclk_i),
    .wclk_i    (wclk_i),
    .sdata_i   (sdata_i),
    .bclk_lvl  (bclk_lvl),
    .wclk_lvl  (wclk_lvl),
    .sdata_lvl (sdata_lvl),
    .bclk_rise (bclk_rise),
    .bclk_fall (bclk_fall)
  );

  sar_framer #(.W(WORD_W), .NW(NARROW_W)) u_framer (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_i        (bit_evt),
    .lr_i         (wclk_lvl),
    .d_i          (sdata_lvl),
    .fmt_i        (fmt),
    .wide_i       (wide_i),
    .done_vld_o   (done_vld),
    .done_right_o (done_right),
    .done_word_o  (done_word)
  );

  sar_pair_out #(.W(WORD_W)) u_pair (
    .clk          (clk),
    .rst_n        (rst_n),
    .done_vld_i   (done_vld),
    .done_right_i (done_right),
    .done_word_i  (done_word),
    .left_o       (left_o),
    .right_o      (right_o),
    .valid_o      (valid_o)
  );
endmodule

// File: rtl/sar_checker.sv
module sar_checker #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   fmt_i,
  input logic         wide_i,
  input logic         bit_evt,
  input logic         bclk_lvl,
  input logic [W-1:0] left_o,
  input logic [W-1:0] right_o,
  input logic         valid_o
);
  always @(posedge clk) begin
    if (!rst_n) AST_RESET_QUIET: assert (!valid_o && left_o == '0 && right_o == '0); // R1
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o))); // R7

  AST_NARROW_ZERO_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !wide_i && $stable(wide_i)) |-> (left_o[1:0] == 2'b00 && right_o[1:0] == 2'b00)); // R6

  AST_RISE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_evt && fmt_i != 2'b11) |-> bclk_lvl); // R2

  AST_DSP_FALL_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_evt && fmt_i == 2'b11) |-> !bclk_lvl); // R5

  AST_STROBE_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(bit_evt, 2)); // R8
endmodule

bind serial_audio_rx sar_checker #(.W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fmt_i    (fmt_i),
  .wide_i   (wide_i),
  .bit_evt  (bit_evt),
  .bclk_lvl (bclk_lvl),
  .left_o   (left_o),
  .right_o  (right_o),
  .valid_o  (valid_o)
);

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, wclk = 1'b0, sd = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic        wide = 1'b1;
  logic [17:0] left_o, right_o;
  logic        valid_o;

  int total = 0, bad = 0, nvalid = 0;
  logic [17:0] last_l = '0, last_r = '0;

  always #5 clk = ~clk;

  serial_audio_rx uut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .wclk_i(wclk), .sdata_i(sd),
    .fmt_i(fmt), .wide_i(wide), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      last_l = left_o;
      last_r = right_o;
      nvalid = nvalid + 1;
    end
  end

  // {fmt[1:0], wide, packed, left[17:0], right[17:0]}
  localparam logic [39:0] VEC [9] = '{
    {2'b00, 1'b1, 1'b0, 18'h2A5C3, 18'h1F00E},
    {2'b00, 1'b0, 1'b0, 18'h08001, 18'h07FFE},
    {2'b00, 1'b0, 1'b1, 18'h0C3A5, 18'h00F1E},
    {2'b01, 1'b1, 1'b0, 18'h3FFFF, 18'h00001},
    {2'b01, 1'b0, 1'b0, 18'h01234, 18'h0FEDC},
    {2'b10, 1'b1, 1'b0, 18'h20000, 18'h1FFFF},
    {2'b10, 1'b0, 1'b1, 18'h0A5A5, 18'h05A5A},
    {2'b11, 1'b1, 1'b0, 18'h15555, 18'h2AAAA},
    {2'b11, 1'b0, 1'b0, 18'h0BEEF, 18'h00042}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bclk = 1'b0; wclk = 1'b0; sd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nvalid = 0;
  endtask

  task automatic slot(input logic lr, input logic d, input int gap);
    wclk = lr; sd = d;
    repeat (2) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
    bclk = 1'b0;
    repeat (2 + gap) @(negedge clk);
  endtask

  function automatic logic lr_at(input logic [1:0] f, input logic is_r, input int k);
    case (f)
      2'b01:   return is_r;
      2'b11:   return k == 0;
      default: return !is_r;
    endcase
  endfunction

  function automatic logic bit_at(input logic [1:0] f, input int n, input int h,
                                  input int k, input logic [17:0] w);
    case (f)
      2'b10:   return (k < n) ? w[n-1-k] : 1'b0;
      2'b00:   return (k >= h - n) ? w[h-1-k] : 1'b0;
      default: return (k >= 1 && k <= n) ? w[n-k] : 1'b0;
    endcase
  endfunction

  task automatic send_half(input logic [1:0] f, input logic w18, input int h,
                           input logic is_r, input logic [17:0] w, input int gap);
    int n = w18 ? 18 : 16;
    for (int k = 0; k < h; k++) slot(lr_at(f, is_r, k), bit_at(f, n, h, k, w), gap);
  endtask

  function automatic logic idle_lr(input logic [1:0] f, input logic to_left);
    if (f == 2'b11) return 1'b0;
    if (f == 2'b01) return !to_left;
    return to_left;
  endfunction

  function automatic logic [17:0] expect_w(input logic w18, input logic [17:0] v);
    return w18 ? v : {v[15:0], 2'b00};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset left", left_o, 0);
    check("R1 reset right", right_o, 0);
    check("R1 reset valid", valid_o, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 9; i++) begin
      logic [1:0]  f  = VEC[i][39:38];
      logic        w18 = VEC[i][37];
      int          h  = VEC[i][36] ? 16 : 32;
      logic [17:0] lv = VEC[i][35:18];
      logic [17:0] rv = VEC[i][17:0];
      string req;
      case (f)
        2'b00: req = "R4";
        2'b01: req = "R3";
        2'b10: req = "R2";
        default: req = "R5";
      endcase
      fmt = f; wide = w18;
      do_reset();
      slot(idle_lr(f, 1'b0), 1'b0, 0);
      slot(idle_lr(f, 1'b0), 1'b0, 0);
      send_half(f, w18, h, 1'b0, lv, 0);
      send_half(f, w18, h, 1'b1, rv, 0);
      slot(idle_lr(f, 1'b1), 1'b0, 0);
      slot(idle_lr(f, 1'b1), 1'b0, 0);
      repeat (10) @(negedge clk);
      check({req, " R6 left word"}, last_l, expect_w(w18, lv));
      check({req, " R6 right word"}, last_r, expect_w(w18, rv));
      check({req, " R7 strobe seen"}, nvalid > 0, 1);
    end

    // R7: no strobe after the left word alone; exactly one after the right
    fmt = 2'b10; wide = 1'b1;
    do_reset();
    slot(1'b0, 1'b0, 0);
    send_half(2'b10, 1'b1, 32, 1'b0, 18'h12345, 0);
    repeat (10) @(negedge clk);
    check("R7 no strobe after left word", nvalid, 0);
    check("R7 outputs hold before pair", left_o, 0);
    send_half(2'b10, 1'b1, 32, 1'b1, 18'h2BCDE, 0);
    repeat (10) @(negedge clk);
    check("R7 one strobe per pair", nvalid, 1);
    check("R7 left after pair", last_l, 18'h12345);

    // R8: long bit-clock stops between every bit, I2S 16-bit
    fmt = 2'b01; wide = 1'b0;
    do_reset();
    slot(1'b1, 1'b0, 17);
    send_half(2'b01, 1'b0, 32, 1'b0, 18'h0C001, 17);
    send_half(2'b01, 1'b0, 32, 1'b1, 18'h03FFC, 23);
    slot(1'b0, 1'b0, 0);
    repeat (10) @(negedge clk);
    check("R8 gated left", last_l, {16'hC001, 2'b00});
    check("R8 gated right", last_r, {16'h3FFC, 2'b00});

    // R5: third pulse is left again in DSP style
    fmt = 2'b11; wide = 1'b1;
    do_reset();
    send_half(2'b11, 1'b1, 32, 1'b0, 18'h00111, 0);
    send_half(2'b11, 1'b1, 32, 1'b1, 18'h00222, 0);
    send_half(2'b11, 1'b1, 32, 1'b0, 18'h30333, 0);
    send_half(2'b11, 1'b1, 32, 1'b1, 18'h00444, 0);
    slot(1'b0, 1'b0, 0);
    repeat (10) @(negedge clk);
    check("R5 second pair left", last_l, 18'h30333);
    check("R5 second pair right", last_r, 18'h00444);
    check("R5 pair count", nvalid, 2);

    // R1: reset after activity clears outputs
    do_reset();
    @(negedge clk);
    check("R1 reset clears left", left_o, 0);
    check("R1 reset clears right", right_o, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule